// File: doc/BRIEF.md
# Banked Program Memory Chip-Enable Decoder

This block sits between a processor's external bus sequencer and a set of off-chip memory devices. It turns a 22-bit external byte address into one of four active-low chip enables. It also decides which of three active-low strobes drives the access: the program read strobe, the data read strobe or the write strobe. The four enables split the bottom of the address space into four adjacent banks of equal size, with bank 0 starting at address zero. A 3-bit size code picks the bank size at run time. The code uses a sparse encoding and resets to the largest setting.

A 4-bit combine mask lets a chosen bank also answer data-move accesses. Writes to that bank then use the write strobe. Reads from it use the program read strobe, not the data read strobe. This lets a single flash device hold code and also be rewritten through data-space writes, for example by a bootstrap loader. The size code and the mask live in a small configuration register that is loaded through `cfg_we`. The sequencer presents one request per cycle as plain control pins. There is no back-pressure: every request is decoded, and its result appears on the registered outputs one cycle later.

Top module: `pmem_bank_decoder`

## Requirements
- R1: All outputs are registered. The outputs seen after rising edge k reflect the request presented at edge k. While `rst_n` is low, every enable and strobe is high.
- R2: Reset sets the size code to 3'b111 and the combine mask to 4'b0000. A configuration write at edge k first affects the request presented at edge k+1.
- R3: The bank size S is 2^15 bytes for code 3'b000, 2^17 for 3'b100, 2^18 for 3'b101, 2^19 for 3'b110 and 2^20 for 3'b111. Enable `ce_n[n]` covers the addresses from n*S to (n+1)*S-1.
- R4: The codes 3'b001, 3'b010 and 3'b011 decode exactly like 3'b000.
- R5: For an address at or above 4*S, no enable goes low. A code read there also asserts no strobe.
- R6: A code read (`acc_data`=0, `rd_req`=1, `wr_req`=0) inside bank n drives `ce_n[n]` and `pstrb_n` low.
- R7: A code-type write (`acc_data`=0, `wr_req`=1, `rd_req`=0) has no effect: every output stays high.
- R8: A data access (`acc_data`=1) inside bank n with mask bit n set drives `ce_n[n]` low. A read also drives `pstrb_n` low and leaves `drd_n` high. A write drives `dwr_n` low.
- R9: A data access that does not fall in a combined bank leaves every enable high. A read drives `drd_n` low and a write drives `dwr_n` low.
- R10: A request with both `rd_req` and `wr_req` high, or with neither, is idle: every output is high.
- R11: At most one enable is low at a time. Whenever an enable is low, exactly one strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads `cfg_size` and `cfg_mask` into the configuration register |
| cfg_size | input | 3 | New bank size code |
| cfg_mask | input | 4 | New combine mask, bit n for bank n |
| addr | input | 22 | External byte address of the request |
| acc_data | input | 1 | 0 = code fetch, 1 = data move |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| ce_n | output | 4 | Active-low bank chip enables |
| pstrb_n | output | 1 | Active-low program read strobe |
| drd_n | output | 1 | Active-low data read strobe |
| dwr_n | output | 1 | Active-low write strobe |

## Verification
Each size code is used for sweeps at bank edges. The sweeps probe the last byte of one bank and the first byte of the next, and the last byte below 4*S and the first byte at 4*S. These tell a wrong shift amount from an off-by-one range check. The reserved codes go through the same sweep, so any decode that differs from 3'b000 shows up. Every edge address is tried with each access kind (code read, code write, data read, data write, both, none) under two complementary combine masks. This separates the combined and uncombined strobe routing bank by bank. A long random run then mixes configuration writes with requests in the same cycle, which exposes a register update that lands one cycle early or late.

// File: rtl/pmem_dec_pkg.sv
package pmem_dec_pkg;

  // Extra shift applied on top of the smallest bank size for each size code.
  function automatic int unsigned size_extra_shift(input logic [2:0] code);
    case (code)
      3'b100:  return 2;
      3'b101:  return 3;
      3'b110:  return 4;
      3'b111:  return 5;
      default: return 0; // 000 and reserved 001/010/011
    endcase
  endfunction

  typedef struct packed {
    logic code_rd;
    logic code_wr;
    logic data_rd;
    logic data_wr;
  } req_kind_t;

  function automatic req_kind_t classify(input logic is_data,
                                         input logic rd,
                                         input logic wr);
    req_kind_t k;
    k.code_rd = !is_data && rd && !wr;
    k.code_wr = !is_data && wr && !rd;
    k.data_rd =  is_data && rd && !wr;
    k.data_wr =  is_data && wr && !rd;
    return k;
  endfunction

endpackage

// File: rtl/pmem_bank_match.sv
module pmem_bank_match #(
  parameter int ADDR_W     = 22,
  parameter int NUM_CE     = 4,
  parameter int BASE_SHIFT = 15,
  localparam int IDX_W     = (NUM_CE > 1) ? $clog2(NUM_CE) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size_code,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  import pmem_dec_pkg::*;

  int unsigned           shamt;
  logic [ADDR_W-1:0]     upper;

  always_comb begin
    shamt = BASE_SHIFT + size_extra_shift(size_code);
    upper = addr >> shamt;
    hit   = (upper < ADDR_W'(NUM_CE));
    idx   = upper[IDX_W-1:0];
  end

endmodule

// File: rtl/pmem_ce_route.sv
module pmem_ce_route #(
  parameter int NUM_CE  = 4,
  localparam int IDX_W  = (NUM_CE > 1) ? $clog2(NUM_CE) : 1
) (
  input  pmem_dec_pkg::req_kind_t kind,
  input  logic                    hit,
  input  logic [IDX_W-1:0]        idx,
  input  logic [NUM_CE-1:0]       comb_mask,
  output logic [NUM_CE-1:0]       ce_on,
  output logic                    pstrb_on,
  output logic                    drd_on,
  output logic                    dwr_on
);
  logic in_combined;
  logic data_any;

  assign data_any = kind.data_rd || kind.data_wr;

  for (genvar n = 0; n < NUM_CE; n++) begin : g_bank
    logic sel;
    assign sel      = hit && (idx == IDX_W'(n));
    assign ce_on[n] = sel && (kind.code_rd || (data_any && comb_mask[n]));
  end

  assign in_combined = hit && comb_mask[idx];

  always_comb begin
    pstrb_on = (kind.code_rd && hit) || (kind.data_rd && in_combined);
    drd_on   = kind.data_rd && !in_combined;
    dwr_on   = kind.data_wr;
  end

  // R11: the combinational enable vector never selects two banks
  always_comb begin
    a_r11_single_bank: assert ($onehot0(ce_on));
  end

endmodule

// File: rtl/pmem_bank_decoder.sv
module pmem_bank_decoder #(
  parameter int ADDR_W     = 22,
  parameter int NUM_CE     = 4,
  parameter int BASE_SHIFT = 15,
  localparam int IDX_W     = (NUM_CE > 1) ? $clog2(NUM_CE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_size,
  input  logic [NUM_CE-1:0] cfg_mask,
  input  logic [ADDR_W-1:0] addr,
  input  logic              acc_data,
  input  logic              rd_req,
  input  logic              wr_req,
  output logic [NUM_CE-1:0] ce_n,
  output logic              pstrb_n,
  output logic              drd_n,
  output logic              dwr_n
);
  import pmem_dec_pkg::*;

  localparam logic [2:0] SIZE_RST = 3'b111;

  logic [2:0]        size_q;
  logic [NUM_CE-1:0] mask_q;
  req_kind_t         kind;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [NUM_CE-1:0] ce_on;
  logic              pstrb_on, drd_on, dwr_on;

  // Configuration register (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SIZE_RST;
      mask_q <= '0;
    end else if (cfg_we) begin
      size_q <= cfg_size;
      mask_q <= cfg_mask;
    end
  end

  assign kind = classify(acc_data, rd_req, wr_req);

  pmem_bank_match #(
    .ADDR_W(ADDR_W), .NUM_CE(NUM_CE), .BASE_SHIFT(BASE_SHIFT)
  ) u_match (
    .addr(addr), .size_code(size_q), .hit(hit), .idx(idx)
  );

  pmem_ce_route #(.NUM_CE(NUM_CE)) u_route (
    .kind(kind), .hit(hit), .idx(idx), .comb_mask(mask_q),
    .ce_on(ce_on), .pstrb_on(pstrb_on), .drd_on(drd_on), .dwr_on(dwr_on)
  );

  // Output register (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n    <= '1;
      pstrb_n <= 1'b1;
      drd_n   <= 1'b1;
      dwr_n   <= 1'b1;
    end else begin
      ce_n    <= ~ce_on;
      pstrb_n <= ~pstrb_on;
      drd_n   <= ~drd_on;
      dwr_n   <= ~dwr_on;
    end
  end

  // R11: one enable at most, and an active enable carries exactly one strobe
  a_r11_onehot_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));
  a_r11_ce_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n != '1) |-> ($countones({pstrb_n, drd_n, dwr_n}) == 2));
  // R10: a request with both or neither of read/write produces nothing
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req == wr_req) |=> (ce_n == '1 && pstrb_n && drd_n && dwr_n));
  // R7: a code-type write never reaches the pins
  a_r7_code_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_data && wr_req && !rd_req) |=> (ce_n == '1 && pstrb_n && dwr_n));
  // R8: data read strobe never accompanies an active program enable
  a_r8_no_drd_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n != '1) |-> drd_n);
  // R6: with the largest banks every code read lands on a bank
  a_r6_full_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (size_q == 3'b111 && !cfg_we && !acc_data && rd_req && !wr_req)
      |=> (!pstrb_n && ce_n != '1));

endmodule

// File: tb/pmem_bank_decoder_tb.sv
module pmem_bank_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_size = 3'b000;
  logic [3:0]  cfg_mask = 4'b0000;
  logic [21:0] addr = '0;
  logic        acc_data = 1'b0;
  logic        rd_req = 1'b0;
  logic        wr_req = 1'b0;
  logic [3:0]  ce_n;
  logic        pstrb_n, drd_n, dwr_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int          m_size = 7;
  logic [3:0]  m_mask = 4'b0000;
  logic [6:0]  exp_out = 7'h7F;
  string       exp_tag = "R1";
  string       phase = "R1";

  always #2 clk = ~clk;

  pmem_bank_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_size(cfg_size),
    .cfg_mask(cfg_mask), .addr(addr), .acc_data(acc_data),
    .rd_req(rd_req), .wr_req(wr_req), .ce_n(ce_n), .pstrb_n(pstrb_n),
    .drd_n(drd_n), .dwr_n(dwr_n)
  );

  function automatic int bank_bits(input int code);
    case (code)
      4: return 17;
      5: return 18;
      6: return 19;
      7: return 20;
      default: return 15;
    endcase
  endfunction

  // Behavioural expectation for one request under the model's config.
  task automatic predict();
    int  sz, bank;
    bit  rd, wr, comb, inb;
    logic [3:0] ce;
    logic p, d, w;
    string k;
    sz   = 1 << bank_bits(m_size);
    bank = int'(addr) / sz;
    inb  = (bank < 4);
    rd   = rd_req && !wr_req;
    wr   = wr_req && !rd_req;
    comb = inb && m_mask[bank % 4];
    ce = 4'hF; p = 1; d = 1; w = 1;
    if (!rd && !wr) k = "R10";
    else if (!acc_data) begin
      if (wr) k = "R7";
      else if (!inb) k = "R5";
      else begin k = "R6"; ce[bank] = 0; p = 0; end
    end else if (comb) begin
      k = "R8"; ce[bank] = 0;
      if (rd) p = 0; else w = 0;
    end else begin
      k = inb ? "R9" : "R5";
      if (rd) d = 0; else w = 0;
    end
    exp_out = {ce, p, d, w};
    exp_tag = {phase, "/", k};
  endtask

  task automatic compare();
    logic [6:0] act;
    act = {ce_n, pstrb_n, drd_n, dwr_n};
    n_cmp++;
    if (act !== exp_out) begin
      n_bad++;
      $display("FAIL %s: outputs {ce_n,pstrb_n,drd_n,dwr_n} actual %b expected %b at %0t",
               exp_tag, act, exp_out, $time);
    end
  endtask

  // One cycle: compare the previous result, then present a new request.
  task automatic step(input logic [21:0] a, input logic dt, input logic r,
                      input logic w, input logic we, input logic [2:0] sc,
                      input logic [3:0] mk);
    @(negedge clk);
    compare();
    addr = a; acc_data = dt; rd_req = r; wr_req = w;
    cfg_we = we; cfg_size = sc; cfg_mask = mk;
    predict();           // uses config before this cycle's write (R2)
    if (we) begin m_size = int'(sc); m_mask = mk; end
  endtask

  task automatic set_cfg(input logic [2:0] sc, input logic [3:0] mk);
    step('0, 1'b0, 1'b0, 1'b0, 1'b1, sc, mk);
  endtask

  task automatic sweep_edges();
    int sz;
    logic [21:0] pts [8];
    sz = 1 << bank_bits(m_size);
    pts[0] = 22'(0);       pts[1] = 22'(sz - 1);
    pts[2] = 22'(sz);      pts[3] = 22'(2*sz - 1);
    pts[4] = 22'(3*sz);    pts[5] = 22'(4*sz - 1);
    pts[6] = 22'(4*sz);    pts[7] = 22'h3FFFFF;
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 6; k++) begin
        case (k)
          0: step(pts[i], 1'b0, 1'b1, 1'b0, 1'b0, 3'b0, 4'b0);
          1: step(pts[i], 1'b0, 1'b0, 1'b1, 1'b0, 3'b0, 4'b0);
          2: step(pts[i], 1'b1, 1'b1, 1'b0, 1'b0, 3'b0, 4'b0);
          3: step(pts[i], 1'b1, 1'b0, 1'b1, 1'b0, 3'b0, 4'b0);
          4: step(pts[i], 1'b1, 1'b1, 1'b1, 1'b0, 3'b0, 4'b0);
          default: step(pts[i], 1'b0, 1'b0, 1'b0, 1'b0, 3'b0, 4'b0);
        endcase
      end
    end
  endtask

  initial begin
    int codes [8] = '{0, 4, 5, 6, 7, 1, 2, 3};
    // R1: outputs held high during reset
    phase = "R1";
    repeat (3) begin @(negedge clk); compare(); end
    @(negedge clk); rst_n = 1'b1;
    // R2: reset size 111 -> top byte maps to CE3, mask 0 keeps data off CEs
    phase = "R2";
    step(22'h3FFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 3'b0, 4'b0);
    step(22'h000000, 1'b1, 1'b1, 1'b0, 1'b0, 3'b0, 4'b0);
    step(22'h0FFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 3'b0, 4'b0);
    // R3 for valid codes, R4 for reserved codes
    for (int c = 0; c < 8; c++) begin
      phase = (codes[c] >= 1 && codes[c] <= 3) ? "R4" : "R3";
      set_cfg(3'(codes[c]), 4'b0101);
      sweep_edges();
      set_cfg(3'(codes[c]), 4'b1010);
      sweep_edges();
    end
    // R2: config written alongside a request; request uses the old config
    phase = "R2";
    set_cfg(3'b111, 4'b0000);
    step(22'h100000, 1'b1, 1'b1, 1'b0, 1'b1, 3'b000, 4'b1111);
    step(22'h100000, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 4'b0000);
    // R11: random mix of requests and configuration writes
    phase = "R11";
    for (int i = 0; i < 3000; i++) begin
      logic we;
      we = ($urandom_range(0, 15) == 0);
      step(22'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           we, 3'($urandom), 4'($urandom));
    end
    @(negedge clk); compare();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule